// File: doc/BRIEF.md
# Asynchronous Static RAM Controller

This block sits between clocked on-chip logic and an external asynchronous static RAM that has a 16-bit data bus, a 19-bit address, two chip selects of opposite polarity, active-low read and write strobes and one active-low enable per byte lane. The user side issues one access at a time. It presents a request with an address, write data, a lane mask and a write flag. When that access is complete, the block gives a single-cycle completion pulse, and for a read it also returns the captured data.

Every phase of an access has a length in whole clock cycles. These lengths are derived at elaboration time from nanosecond timing parameters for the chosen memory speed grade and the clock period. Each conversion rounds up and never yields fewer than one cycle. The bidirectional data bus is split into an output value, a drive enable and an input value, so the pad ring can build the tri-state buffer. The controller turns on that drive enable only while it is presenting write data. After every read it keeps the bus undriven for long enough that the memory's outputs have floated.

Top module: `sram_ctl`

## Requirements
- R1: After reset and whenever no access is in progress, the memory is deselected: `mem_cs1_n`=1, `mem_cs2`=0, `mem_oe_n`=1, `mem_we_n`=1, every lane enable high, `mem_dq_oe`=0. In addition, `rsp_done`=0 and `rsp_rdata`=0 after reset.
- R2: During every phase of an access, both chip selects are asserted together (`mem_cs1_n`=0, `mem_cs2`=1). Outside an access, both are deasserted together.
- R3: Mask bit i of `req_lanes` selects data bits [8i+7:8i]. Lane enable `mem_lane_n[i]` is driven low during the access only when mask bit i is 1. A mask of 00 leaves both lane enables high, so the memory stays in standby. Read data bits of lanes that were not enabled are returned as 0.
- R4: A read holds the address with `mem_oe_n`=0 and `mem_we_n`=1 for RD = max(ceil(tRC), ceil(tAA), ceil(tOE)) cycles, which is 14 cycles at 70 ns and 5 ns per cycle. `rsp_rdata` is loaded from `mem_dq_in` at the end of the last of those cycles.
- R5: A read is followed by TA = ceil(tHZ) fully deselected cycles (5 cycles). The bus is not driven during these cycles.
- R6: A write starts with SU = ceil(tAS), minimum 1, setup cycles. In these cycles the selects and lane enables are asserted, `mem_we_n`=1, and `mem_dq_oe`=1 with `mem_dq_out` carrying the write data.
- R7: The write strobe `mem_we_n` is then held low for WP = max(ceil(tWP), ceil(tDW), ceil(tAW)-SU, ceil(tWC)-SU-REC) cycles, which is 12 cycles. During this time the bus is driven, and the address and data do not change.
- R8: A write ends by raising `mem_we_n` while the selects and lane enables stay asserted for REC = ceil(tWR), minimum 1, cycles. The bus driver is off during these cycles.
- R9: `rsp_done` is high for exactly the final cycle of each access. A request presented on the following cycle is accepted at once.
- R10: A request is accepted only when no access is in progress. Requests presented during an access are ignored and do not change any pin of the access in progress.
- R11: `mem_dq_oe` is never high while `mem_oe_n` is low, nor while the memory may still be driving the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request, taken when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Word address |
| req_wdata | input | 16 | Write data |
| req_lanes | input | 2 | Byte lane mask, bit 0 = bits 7:0 |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Captured read data |
| mem_addr | output | 19 | Memory address |
| mem_cs1_n | output | 1 | Active-low chip select |
| mem_cs2 | output | 1 | Active-high chip select |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_lane_n | output | 2 | Active-low lane enables, bit 0 = lower byte |
| mem_dq_out | output | 16 | Data to memory |
| mem_dq_oe | output | 1 | Data bus drive enable |
| mem_dq_in | input | 16 | Data from memory |

## Verification
The assertions check several properties on every cycle: the chip selects switch as a pair; a write strobe appears only with the chip selected and the bus driven; the address and data are stable while the write strobe is low; a write ends with the selects still held; the drive enable is never on with the read strobe low; and the completion pulse lasts one cycle. Only the bench scenarios can show the exact phase lengths, the merging of byte lanes across separate writes, the zeroing of disabled read lanes, and the ignoring of requests that arrive during an access. The bench's memory model also confirms that the controller leaves the bus alone until the device has stopped driving it after a read, and that each write meets its pulse-width and setup rules.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_READ,
        PH_TURN,
        PH_WSETUP,
        PH_WPULSE,
        PH_WREC
    } phase_e;

    // nanoseconds to whole cycles, rounded up, never below one
    function automatic int ns_to_cyc(int ns, int clk_ns);
        int c;
        c = (ns + clk_ns - 1) / clk_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int imax(int a, int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_ctl_seq.sv
module sram_ctl_seq
    import sram_ctl_pkg::*;
#(
    parameter int RD_LEN  = 14,
    parameter int TA_LEN  = 5,
    parameter int SU_LEN  = 1,
    parameter int WP_LEN  = 12,
    parameter int REC_LEN = 1
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   req,
    input  logic   req_we,
    output phase_e phase,
    output logic   accept,
    output logic   last
);
    localparam int MAXLEN = imax(imax(imax(RD_LEN, TA_LEN), imax(SU_LEN, WP_LEN)), REC_LEN);
    localparam int CNT_W  = $clog2(MAXLEN + 1);

    localparam logic [CNT_W-1:0] RD_C  = CNT_W'(RD_LEN - 1);
    localparam logic [CNT_W-1:0] TA_C  = CNT_W'(TA_LEN - 1);
    localparam logic [CNT_W-1:0] SU_C  = CNT_W'(SU_LEN - 1);
    localparam logic [CNT_W-1:0] WP_C  = CNT_W'(WP_LEN - 1);
    localparam logic [CNT_W-1:0] REC_C = CNT_W'(REC_LEN - 1);

    logic [CNT_W-1:0] cnt;

    assign accept = (phase == PH_IDLE) && req;
    assign last   = (phase != PH_IDLE) && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            cnt   <= '0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (req) begin
                        if (req_we) begin
                            phase <= PH_WSETUP;
                            cnt   <= SU_C;
                        end else begin
                            phase <= PH_READ;
                            cnt   <= RD_C;
                        end
                    end
                end
                PH_READ: begin
                    if (cnt == '0) begin
                        phase <= PH_TURN;
                        cnt   <= TA_C;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_TURN: begin
                    if (cnt == '0) phase <= PH_IDLE;
                    else           cnt   <= cnt - 1'b1;
                end
                PH_WSETUP: begin
                    if (cnt == '0) begin
                        phase <= PH_WPULSE;
                        cnt   <= WP_C;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_WPULSE: begin
                    if (cnt == '0) begin
                        phase <= PH_WREC;
                        cnt   <= REC_C;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_WREC: begin
                    if (cnt == '0) phase <= PH_IDLE;
                    else           cnt   <= cnt - 1'b1;
                end
                default: begin
                    phase <= PH_IDLE;
                    cnt   <= '0;
                end
            endcase
        end
    end

    // R8: the strobe phase always hands over to the recovery phase
    assert_pulse_then_recover_R8: assert property (@(posedge clk) disable iff (rst)
        ($past(phase) == PH_WPULSE && phase != PH_WPULSE) |-> (phase == PH_WREC));

    // R5: a read always hands over to the turnaround phase
    assert_read_then_turn_R5: assert property (@(posedge clk) disable iff (rst)
        ($past(phase) == PH_READ && phase != PH_READ) |-> (phase == PH_TURN));

endmodule

// File: rtl/sram_ctl_pins.sv
module sram_ctl_pins
    import sram_ctl_pkg::*;
#(
    parameter int ADDR_W = 19,
    parameter int LANES  = 2,
    parameter int LANE_W = 8
) (
    input  phase_e                  phase,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic [LANES-1:0]        lanes,
    output logic [ADDR_W-1:0]       mem_addr,
    output logic                    mem_cs1_n,
    output logic                    mem_cs2,
    output logic                    mem_oe_n,
    output logic                    mem_we_n,
    output logic [LANES-1:0]        mem_lane_n,
    output logic [LANES*LANE_W-1:0] mem_dq_out,
    output logic                    mem_dq_oe
);
    logic sel;

    always_comb begin
        sel = (phase == PH_READ)   || (phase == PH_WSETUP) ||
              (phase == PH_WPULSE) || (phase == PH_WREC);
    end

    assign mem_addr   = addr;
    assign mem_cs1_n  = ~sel;
    assign mem_cs2    = sel;
    assign mem_oe_n   = (phase != PH_READ);
    assign mem_we_n   = (phase != PH_WPULSE);
    assign mem_dq_oe  = (phase == PH_WSETUP) || (phase == PH_WPULSE);
    assign mem_dq_out = wdata;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign mem_lane_n[i] = ~(sel & lanes[i]);
    end

endmodule

// File: rtl/sram_ctl_rdcap.sv
module sram_ctl_rdcap #(
    parameter int LANES  = 2,
    parameter int LANE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    capture,
    input  logic [LANES-1:0]        lanes,
    input  logic [LANES*LANE_W-1:0] dq_in,
    output logic [LANES*LANE_W-1:0] rdata
);
    for (genvar i = 0; i < LANES; i++) begin : g_cap
        always_ff @(posedge clk) begin
            if (rst) begin
                rdata[i*LANE_W +: LANE_W] <= '0;
            end else if (capture) begin
                rdata[i*LANE_W +: LANE_W] <= lanes[i] ? dq_in[i*LANE_W +: LANE_W] : '0;
            end
        end
    end

endmodule

// File: rtl/sram_ctl.sv
module sram_ctl
    import sram_ctl_pkg::*;
#(
    parameter int CLK_NS  = 5,
    parameter int ADDR_W  = 19,
    parameter int LANES   = 2,
    parameter int LANE_W  = 8,
    parameter int T_RC_NS = 70,
    parameter int T_AA_NS = 70,
    parameter int T_OE_NS = 35,
    parameter int T_HZ_NS = 25,
    parameter int T_WC_NS = 70,
    parameter int T_WP_NS = 55,
    parameter int T_AW_NS = 60,
    parameter int T_DW_NS = 30,
    parameter int T_AS_NS = 0,
    parameter int T_WR_NS = 0
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    req_valid,
    input  logic                    req_write,
    input  logic [ADDR_W-1:0]       req_addr,
    input  logic [LANES*LANE_W-1:0] req_wdata,
    input  logic [LANES-1:0]        req_lanes,
    output logic                    rsp_done,
    output logic [LANES*LANE_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0]       mem_addr,
    output logic                    mem_cs1_n,
    output logic                    mem_cs2,
    output logic                    mem_oe_n,
    output logic                    mem_we_n,
    output logic [LANES-1:0]        mem_lane_n,
    output logic [LANES*LANE_W-1:0] mem_dq_out,
    output logic                    mem_dq_oe,
    input  logic [LANES*LANE_W-1:0] mem_dq_in
);
    localparam int DATA_W  = LANES * LANE_W;
    localparam int RD_LEN  = imax(imax(ns_to_cyc(T_RC_NS, CLK_NS), ns_to_cyc(T_AA_NS, CLK_NS)),
                                  ns_to_cyc(T_OE_NS, CLK_NS));
    localparam int TA_LEN  = ns_to_cyc(T_HZ_NS, CLK_NS);
    localparam int SU_LEN  = ns_to_cyc(T_AS_NS, CLK_NS);
    localparam int REC_LEN = ns_to_cyc(T_WR_NS, CLK_NS);
    localparam int WP_LEN  = imax(imax(ns_to_cyc(T_WP_NS, CLK_NS), ns_to_cyc(T_DW_NS, CLK_NS)),
                                  imax(ns_to_cyc(T_AW_NS, CLK_NS) - SU_LEN,
                                       ns_to_cyc(T_WC_NS, CLK_NS) - SU_LEN - REC_LEN));

    phase_e              phase;
    logic                accept;
    logic                last;
    logic [ADDR_W-1:0]   r_addr;
    logic [DATA_W-1:0]   r_wdata;
    logic [LANES-1:0]    r_lanes;

    // request is held for the whole access
    always_ff @(posedge clk) begin
        if (rst) begin
            r_addr  <= '0;
            r_wdata <= '0;
            r_lanes <= '0;
        end else if (accept) begin
            r_addr  <= req_addr;
            r_wdata <= req_wdata;
            r_lanes <= req_lanes;
        end
    end

    sram_ctl_seq #(
        .RD_LEN (RD_LEN),
        .TA_LEN (TA_LEN),
        .SU_LEN (SU_LEN),
        .WP_LEN (WP_LEN),
        .REC_LEN(REC_LEN)
    ) u_seq (
        .clk   (clk),
        .rst   (rst),
        .req   (req_valid),
        .req_we(req_write),
        .phase (phase),
        .accept(accept),
        .last  (last)
    );

    sram_ctl_pins #(
        .ADDR_W(ADDR_W),
        .LANES (LANES),
        .LANE_W(LANE_W)
    ) u_pins (
        .phase     (phase),
        .addr      (r_addr),
        .wdata     (r_wdata),
        .lanes     (r_lanes),
        .mem_addr  (mem_addr),
        .mem_cs1_n (mem_cs1_n),
        .mem_cs2   (mem_cs2),
        .mem_oe_n  (mem_oe_n),
        .mem_we_n  (mem_we_n),
        .mem_lane_n(mem_lane_n),
        .mem_dq_out(mem_dq_out),
        .mem_dq_oe (mem_dq_oe)
    );

    sram_ctl_rdcap #(
        .LANES (LANES),
        .LANE_W(LANE_W)
    ) u_cap (
        .clk    (clk),
        .rst    (rst),
        .capture(last && (phase == PH_READ)),
        .lanes  (r_lanes),
        .dq_in  (mem_dq_in),
        .rdata  (rsp_rdata)
    );

    assign rsp_done = last && ((phase == PH_TURN) || (phase == PH_WREC));

    // R2: the two selects always move as a pair
    assert_cs_pair_R2: assert property (@(posedge clk) disable iff (rst)
        mem_cs1_n == ~mem_cs2);

    // R11: never drive while the memory is asked to drive
    assert_no_contention_R11: assert property (@(posedge clk) disable iff (rst)
        mem_dq_oe |-> mem_oe_n);

    // R7: write strobe only with the chip selected and data on the bus
    assert_strobe_context_R7: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> (!mem_cs1_n && mem_cs2 && mem_dq_oe && mem_oe_n));

    // R7: address and data frozen while the strobe is low
    assert_strobe_stable_R7: assert property (@(posedge clk) disable iff (rst)
        (!mem_we_n && !$past(mem_we_n)) |-> ($stable(mem_addr) && $stable(mem_dq_out)));

    // R8: strobe released while the selects are still held and the bus released
    assert_write_end_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_we_n) |-> (!mem_cs1_n && mem_cs2 && !mem_dq_oe));

    // R5: the read strobe is released together with the selects
    assert_read_end_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_oe_n) |-> (mem_cs1_n && !mem_dq_oe));

    // R9: completion is a single-cycle pulse
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        rsp_done |=> !rsp_done);

endmodule

// File: tb/sim_sram_ctl.sv
`timescale 1ns/1ps
module sim_sram_ctl;
    localparam int CLK_NS = 5;

    function automatic int cyc(int ns);
        int c;
        c = (ns + CLK_NS - 1) / CLK_NS;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int mx(int a, int b);
        return (a > b) ? a : b;
    endfunction

    localparam int RD  = mx(mx(cyc(70), cyc(70)), cyc(35));
    localparam int TA  = cyc(25);
    localparam int SU  = cyc(0);
    localparam int REC = cyc(0);
    localparam int WP  = mx(mx(cyc(55), cyc(30)), mx(cyc(60) - SU, cyc(70) - SU - REC));
    localparam int AA_MIN = cyc(70);
    localparam int WP_MIN = cyc(55);
    localparam int DW_MIN = cyc(30);
    localparam int AW_MIN = cyc(60);
    localparam int HZ_CYC = cyc(25);

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic        rst;
    logic        req_valid;
    logic        req_write;
    logic [18:0] req_addr;
    logic [15:0] req_wdata;
    logic [1:0]  req_lanes;
    logic        rsp_done;
    logic [15:0] rsp_rdata;
    logic [18:0] mem_addr;
    logic        mem_cs1_n;
    logic        mem_cs2;
    logic        mem_oe_n;
    logic        mem_we_n;
    logic [1:0]  mem_lane_n;
    logic [15:0] mem_dq_out;
    logic        mem_dq_oe;
    logic [15:0] mem_dq_in;

    sram_ctl u0 (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_lanes(req_lanes),
        .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
        .mem_addr(mem_addr), .mem_cs1_n(mem_cs1_n), .mem_cs2(mem_cs2),
        .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_lane_n(mem_lane_n),
        .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    int checks = 0;
    int fails  = 0;

    task automatic chk(bit ok, string rq, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", rq, what, act, exp, $time);
        end
    endtask

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    // ---------------- golden contents ----------------
    logic [15:0] gold [int];
    function automatic logic [15:0] gold_rd(int a);
        return gold.exists(a) ? gold[a] : 16'h0000;
    endfunction

    // ---------------- cycle reference model ----------------
    bit          m_busy;
    bit          m_we;
    int          k;
    int          m_len;
    logic [18:0] m_addr;
    logic [15:0] m_wd;
    logic [1:0]  m_lanes;
    logic [15:0] m_rexp;

    always @(posedge clk) begin
        if (rst) begin
            m_busy = 1'b0;
            k = 0;
        end else if (m_busy) begin
            if (k == m_len - 1) m_busy = 1'b0;
            else k++;
        end else if (req_valid) begin
            m_busy  = 1'b1;
            k       = 0;
            m_we    = req_write;
            m_addr  = req_addr;
            m_wd    = req_wdata;
            m_lanes = req_lanes;
            m_len   = req_write ? (SU + WP + REC) : (RD + TA);
            if (req_write) begin
                logic [15:0] w;
                w = gold_rd(int'(req_addr));
                if (req_lanes[0]) w[7:0]  = req_wdata[7:0];
                if (req_lanes[1]) w[15:8] = req_wdata[15:8];
                gold[int'(req_addr)] = w;
            end else begin
                m_rexp = gold_rd(int'(req_addr));
                if (!req_lanes[0]) m_rexp[7:0]  = 8'h00;
                if (!req_lanes[1]) m_rexp[15:8] = 8'h00;
            end
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            bit sel, oe_n, we_n, drv, dn;
            string tg;
            sel = 0; oe_n = 1; we_n = 1; drv = 0; dn = 0; tg = "R1";
            if (m_busy) begin
                dn = (k == m_len - 1);
                if (m_we) begin
                    sel = 1;
                    if (k < SU) begin
                        tg = "R6"; drv = 1;
                    end else if (k < SU + WP) begin
                        tg = "R7"; drv = 1; we_n = 0;
                    end else begin
                        tg = "R8";
                    end
                end else if (k < RD) begin
                    tg = "R4"; sel = 1; oe_n = 0;
                end else begin
                    tg = "R5";
                end
            end
            chk(mem_cs1_n == !sel && mem_cs2 == sel, "R2", "selects",
                {30'd0, mem_cs1_n, mem_cs2}, {30'd0, !sel, sel});
            chk(mem_oe_n == oe_n && mem_we_n == we_n, tg, "strobes",
                {30'd0, mem_oe_n, mem_we_n}, {30'd0, oe_n, we_n});
            chk(mem_dq_oe == drv, tg, "drive", {31'd0, mem_dq_oe}, {31'd0, drv});
            chk(mem_lane_n == ~(m_lanes & {2{sel}}), "R3", "lanes",
                {30'd0, mem_lane_n}, {30'd0, ~(m_lanes & {2{sel}})});
            chk(rsp_done == dn, "R9", "done", {31'd0, rsp_done}, {31'd0, dn});
            if (sel)
                chk(mem_addr == m_addr, "R10", "addr", {13'd0, mem_addr}, {13'd0, m_addr});
            if (drv)
                chk(mem_dq_out == m_wd, "R10", "wdata", {16'd0, mem_dq_out}, {16'd0, m_wd});
            if (dn && !m_we)
                chk(rsp_rdata == m_rexp, "R4", "rdata", {16'd0, rsp_rdata}, {16'd0, m_rexp});
        end
    end

    // ---------------- behavioural memory ----------------
    logic [15:0] ram [int];
    int          rd_age, hz, wp_age, dstab, astab;
    int          e_dstab, e_astab;
    bit          was_wr;
    logic [18:0] prev_addr, w_addr;
    logic [15:0] prev_out, w_data;
    logic [1:0]  w_lanes;

    always @(negedge clk) begin
        if (rst) begin
            rd_age = 0; hz = 0; wp_age = 0; dstab = 0; astab = 0; was_wr = 0;
            mem_dq_in = 16'h0000;
        end else begin
            bit sel, act_rd, act_wr;
            logic [15:0] word;
            sel    = !mem_cs1_n && mem_cs2 && (mem_lane_n != 2'b11);
            act_rd = sel && !mem_oe_n && mem_we_n;
            act_wr = sel && !mem_we_n;
            if (mem_dq_oe)
                chk(!(act_rd || hz > 0), "R11", "bus contention",
                    {31'd0, mem_dq_oe}, 32'd0);
            // read side
            if (act_rd && mem_addr == prev_addr && rd_age > 0) rd_age++;
            else if (act_rd) rd_age = 1;
            else rd_age = 0;
            hz = act_rd ? HZ_CYC : ((hz > 0) ? hz - 1 : 0);
            word = ram.exists(int'(mem_addr)) ? ram[int'(mem_addr)] : 16'h0000;
            if (act_rd || hz > 0) begin
                mem_dq_in[7:0]  = (act_rd && !mem_lane_n[0] && rd_age >= AA_MIN) ? word[7:0]  : 8'hC3;
                mem_dq_in[15:8] = (act_rd && !mem_lane_n[1] && rd_age >= AA_MIN) ? word[15:8] : 8'hC3;
            end else begin
                mem_dq_in = 16'h0000;
            end
            // write side
            dstab = mem_dq_oe ? ((mem_dq_out == prev_out && dstab > 0) ? dstab + 1 : 1) : 0;
            astab = sel ? ((mem_addr == prev_addr && astab > 0) ? astab + 1 : 1) : 0;
            if (act_wr) begin
                wp_age++;
                e_dstab = dstab; e_astab = astab;
                w_addr = mem_addr; w_data = mem_dq_out; w_lanes = ~mem_lane_n;
            end else if (was_wr) begin
                chk(wp_age >= WP_MIN, "R7", "write pulse cycles", wp_age, WP_MIN);
                chk(e_dstab >= DW_MIN, "R7", "data setup cycles", e_dstab, DW_MIN);
                chk(e_astab >= AW_MIN, "R7", "address to end cycles", e_astab, AW_MIN);
                word = ram.exists(int'(w_addr)) ? ram[int'(w_addr)] : 16'h0000;
                if (w_lanes[0]) word[7:0]  = w_data[7:0];
                if (w_lanes[1]) word[15:8] = w_data[15:8];
                ram[int'(w_addr)] = word;
                wp_age = 0;
            end
            was_wr    = act_wr;
            prev_addr = mem_addr;
            prev_out  = mem_dq_out;
        end
    end

    // ---------------- watchdog ----------------
    int wd_cnt = 0;
    always @(posedge clk) begin
        wd_cnt++;
        if (wd_cnt > 100000) begin
            chk(1'b0, "R9", "watchdog expired", wd_cnt, 100000);
            report();
        end
    end

    // ---------------- stimulus ----------------
    task automatic wait_done();
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (rsp_done) return;
        end
        chk(1'b0, "R9", "no done pulse", 0, 1);
    endtask

    task automatic access(bit we, logic [18:0] a, logic [15:0] d, logic [1:0] ln, bit inject);
        @(negedge clk);
        req_valid = 1; req_write = we; req_addr = a; req_wdata = d; req_lanes = ln;
        @(negedge clk);
        req_valid = 0;
        if (inject) begin
            repeat (3) @(negedge clk);
            // R10: request arriving during the access must be ignored
            req_valid = 1; req_write = !we; req_addr = ~a; req_wdata = ~d; req_lanes = ~ln;
            @(negedge clk);
            @(negedge clk);
            req_valid = 0;
        end
        wait_done();
    endtask

    initial begin
        rst = 1; req_valid = 0; req_write = 0; req_addr = '0; req_wdata = '0; req_lanes = '0;
        repeat (4) @(negedge clk);
        // R1: state while in reset
        chk(mem_cs1_n && !mem_cs2 && mem_oe_n && mem_we_n, "R1", "reset strobes",
            {28'd0, mem_cs1_n, mem_cs2, mem_oe_n, mem_we_n}, 32'hB);
        chk(mem_lane_n == 2'b11 && !mem_dq_oe, "R1", "reset lanes/drive",
            {29'd0, mem_lane_n, mem_dq_oe}, 32'h6);
        chk(!rsp_done && rsp_rdata == 16'h0, "R1", "reset outputs",
            {15'd0, rsp_done, rsp_rdata}, 32'h0);
        rst = 0;
        repeat (3) @(negedge clk);

        access(1, 19'h00012, 16'hBEEF, 2'b11, 0);          // word write
        access(0, 19'h00012, 16'h0000, 2'b11, 0);          // word read back (R4)
        access(1, 19'h7FFFF, 16'h1234, 2'b01, 0);          // lower lane only (R3)
        access(1, 19'h7FFFF, 16'hAB99, 2'b10, 0);          // upper lane only (R3)
        access(0, 19'h7FFFF, 16'h0000, 2'b11, 0);          // merged 0xAB34
        access(0, 19'h00012, 16'h0000, 2'b01, 0);          // lower only read, upper zero
        access(0, 19'h00012, 16'h0000, 2'b10, 0);          // upper only read, lower zero
        access(0, 19'h00012, 16'h0000, 2'b00, 0);          // no lanes: standby, zero data
        access(1, 19'h00400, 16'h5AA5, 2'b11, 1);          // R10 during write
        access(0, 19'h00400, 16'h0000, 2'b11, 1);          // R10 during read
        access(1, 19'h00000, 16'hFFFF, 2'b00, 0);          // write with no lanes leaves data
        access(0, 19'h00000, 16'h0000, 2'b11, 0);

        // R9/R5: request held high, read then immediate write then read
        @(negedge clk);
        req_valid = 1; req_write = 0; req_addr = 19'h7FFFF; req_lanes = 2'b11;
        wait_done();
        req_write = 1; req_addr = 19'h00033; req_wdata = 16'hC0DE;
        wait_done();
        req_write = 0;
        wait_done();
        req_valid = 0;
        repeat (5) @(negedge clk);
        // R1: idle after the last access
        chk(mem_cs1_n && !mem_cs2 && mem_oe_n && mem_we_n && !mem_dq_oe, "R1", "idle pins",
            {27'd0, mem_cs1_n, mem_cs2, mem_oe_n, mem_we_n, mem_dq_oe}, 32'h16);
        report();
    end

endmodule